// File: doc/BRIEF.md
# Teletext Bit Timing Sequencer

This block sets the timing for one teletext line in the vertical blanking interval. A 27 MHz clock drives it. A rising edge on the horizontal sync input starts a line, and only if the teletext enable input is high at that edge. The block then opens a request window toward an external serial data source. The window opens early by a programmable delay of 0 to 15 clocks, so a source with that much latency returns its first bit exactly 275 clocks (10.2 µs) after the sync edge.

Teletext bits arrive at 6.9375 Mbit/s, which does not divide the clock evenly. The block approximates that rate with a repeating schedule of 144 clocks per 37 bits. Most bits last four clocks and four bits in each group last three. Each bit is sampled once, on the first clock of its period. It is presented with a one-cycle valid strobe and its index. After 360 bits, the block emits a one-cycle end-of-line pulse and returns to idle.

Top module: `ttx_bit_sequencer`

## Requirements
- R1: A synchronous active-high reset makes the block idle. In every cycle after a clock with reset high, `ttx_req`, `bit_vld` and `line_done` are 0. No line runs until a new sync edge arrives.
- R2: A line starts at a clock where `hsync` is 1, `hsync` was 0 at the previous clock, the block is idle and `ttx_en` is 1. That clock is called the edge clock, and cycle n is the clock period that begins n clocks after it. If `ttx_en` is 0 at the edge clock, no request, no strobe and no end-of-line pulse follow.
- R3: With delay setting D, `ttx_req` is 1 exactly in cycles 275−D through 275−D+1401. That is 1402 consecutive cycles.
- R4: Bit b (0-based) is sampled from `ttx_din` at the clock that ends cycle 275+S(b). S(b) is the sum of the lengths of bits 0 to b−1. 360 bits are sampled per line.
- R5: Let p = b mod 37. Bit b lasts 3 clocks when p is 9, 18, 27 or 36, and 4 clocks otherwise. A full 37-bit group therefore spans 144 clocks, and a line spans 1402.
- R6: Each sampled bit appears on `bit_data` with `bit_vld` high for exactly one cycle, in the cycle after its sample. `bit_idx` carries b, which counts up from 0 to 359.
- R7: `line_done` is high for exactly one cycle, cycle 1677 (275+1402). The request window is already closed in that cycle.
- R8: While a line is active, up to and including its `line_done` cycle, a sync edge neither restarts nor shifts the line. An edge at any later clock starts a new line.
- R9: D is captured at the edge clock. Changing `req_dly` during a line has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Horizontal sync; its rising edge starts a line |
| ttx_en | input | 1 | Teletext enable, sampled at the sync edge |
| req_dly | input | 4 | Request-to-data latency of the source, in clocks (0–15) |
| ttx_req | output | 1 | Data request window toward the source |
| ttx_din | input | 1 | Serial teletext data returned by the source |
| bit_vld | output | 1 | One-cycle strobe for each sampled bit |
| bit_data | output | 1 | Sampled bit value |
| bit_idx | output | 9 | Index of the sampled bit, 0 to 359 |
| line_done | output | 1 | One-cycle end-of-line pulse |

## Verification
The end-of-line pulse and a new sync edge can fall on the same clock. That clock is the last one at which the line still counts as active, so the block must ignore the edge there and accept one that comes any later. The bench raises `hsync` so that its edge lands exactly on the `line_done` cycle. It then checks that no second request window opens. It raises another edge two clocks later and checks that a full new line follows on its own timing. A second overlap is an edge that arrives in the middle of a line while bits are being strobed. Here the bench compares every strobe, index and data value with a schedule it computes itself, to show that nothing shifted.

// File: rtl/ttx_seq_pkg.sv
package ttx_seq_pkg;

    // Number of clocks a teletext line occupies, given the bit schedule:
    // bits whose group position is a non-zero multiple of the stride are one clock short.
    function automatic int line_clocks(input int nbits, input int grp,
                                       input int stride, input int long_clk);
        int s;
        int p;
        s = 0;
        for (int b = 0; b < nbits; b++) begin
            p = b % grp;
            s += ((p != 0) && (p % stride == 0)) ? long_clk - 1 : long_clk;
        end
        return s;
    endfunction

endpackage

// File: rtl/ttx_line_timer.sv
module ttx_line_timer #(
    parameter int START = 275,
    parameter int WIN   = 1402,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync_i,
    input  logic             en_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             done_i,
    output logic             req_o,
    output logic             start_o
);
    localparam int CNT_W = $clog2(START + WIN + 2);
    localparam logic [CNT_W-1:0] START_C = CNT_W'(START);
    localparam logic [CNT_W-1:0] WIN_C   = CNT_W'(WIN);

    typedef struct packed {
        logic             hs;
        logic             act;
        logic [CNT_W-1:0] cnt;
        logic [DLY_W-1:0] dly;
    } tmr_t;

    tmr_t q, d;
    logic edge_seen, launch;
    logic [CNT_W-1:0] req_lo;

    always_comb begin
        d         = q;
        d.hs      = hsync_i;
        edge_seen = hsync_i && !q.hs;
        launch    = edge_seen && en_i && !q.act;
        if (launch) begin
            d.act = 1'b1;
            d.cnt = '0;
            d.dly = dly_i;
        end else if (q.act) begin
            if (done_i) begin
                d.act = 1'b0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
        req_lo  = START_C - CNT_W'(q.dly);
        req_o   = q.act && (q.cnt >= req_lo) && (q.cnt < req_lo + WIN_C);
        start_o = q.act && (q.cnt == START_C);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R8: an active line keeps counting; a sync edge cannot restart it
    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        (q.act && !done_i) |=> (q.act && q.cnt == $past(q.cnt) + 1'b1));

    // R9: captured delay holds for the whole line
    a_r9_dly_held: assert property (@(posedge clk) disable iff (rst)
        (q.act && !done_i) |=> $stable(q.dly));

endmodule

// File: rtl/ttx_bit_sched.sv
module ttx_bit_sched #(
    parameter int NBITS    = 360,
    parameter int GRP      = 37,
    parameter int STRIDE   = 9,
    parameter int LONG_CLK = 4,
    parameter int IW       = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          data_i,
    output logic          vld_o,
    output logic          dat_o,
    output logic [IW-1:0] idx_o,
    output logic          done_o
);
    localparam int LW = $clog2(LONG_CLK);
    localparam int NW = $clog2(NBITS + 1);
    localparam int PW = $clog2(GRP);
    localparam int SW = $clog2(STRIDE);

    typedef struct packed {
        logic          run;
        logic [LW-1:0] left;
        logic [PW-1:0] pos;
        logic [SW-1:0] sub;
        logic [NW-1:0] nb;
        logic          vld;
        logic          dat;
        logic [IW-1:0] idx;
    } sch_t;

    sch_t q, d;
    logic take, fin, short_bit;
    logic [PW-1:0] pos_u;
    logic [SW-1:0] sub_u;
    logic [NW-1:0] nb_u;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        pos_u = start_i ? '0 : q.pos;
        sub_u = start_i ? '0 : q.sub;
        nb_u  = start_i ? '0 : q.nb;
        fin   = q.run && (q.left == '0) && (q.nb == NW'(NBITS));
        take  = start_i || (q.run && (q.left == '0) && (q.nb != NW'(NBITS)));
        short_bit = (pos_u != '0) && (sub_u == '0);
        if (take) begin
            d.run  = 1'b1;
            d.vld  = 1'b1;
            d.dat  = data_i;
            d.idx  = IW'(nb_u);
            d.nb   = nb_u + 1'b1;
            d.left = short_bit ? LW'(LONG_CLK - 2) : LW'(LONG_CLK - 1);
            if (pos_u == PW'(GRP - 1)) begin
                d.pos = '0;
                d.sub = '0;
            end else begin
                d.pos = pos_u + 1'b1;
                d.sub = (sub_u == SW'(STRIDE - 1)) ? '0 : sub_u + 1'b1;
            end
        end else if (q.run) begin
            if (fin) begin
                d.run = 1'b0;
            end else begin
                d.left = q.left - 1'b1;
            end
        end
        vld_o  = q.vld;
        dat_o  = q.dat;
        idx_o  = q.idx;
        done_o = fin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R6: strobes are single cycles separated by at least one idle cycle
    a_r6_vld_gap: assert property (@(posedge clk) disable iff (rst)
        q.vld |=> !q.vld);

    // R6: index never leaves the line
    a_r6_idx_bound: assert property (@(posedge clk) disable iff (rst)
        q.vld |-> (q.idx < IW'(NBITS)));

    // R7: end-of-line lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        fin |=> !fin);

endmodule

// File: rtl/ttx_bit_sequencer.sv
module ttx_bit_sequencer #(
    parameter int NBITS    = 360,
    parameter int GRP      = 37,
    parameter int STRIDE   = 9,
    parameter int LONG_CLK = 4,
    parameter int START    = 275,
    parameter int DLY_W    = 4,
    localparam int IDX_W   = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync,
    input  logic             ttx_en,
    input  logic [DLY_W-1:0] req_dly,
    output logic             ttx_req,
    input  logic             ttx_din,
    output logic             bit_vld,
    output logic             bit_data,
    output logic [IDX_W-1:0] bit_idx,
    output logic             line_done
);
    localparam int WIN = ttx_seq_pkg::line_clocks(NBITS, GRP, STRIDE, LONG_CLK);

    logic seq_start;
    logic seq_done;

    ttx_line_timer #(
        .START (START),
        .WIN   (WIN),
        .DLY_W (DLY_W)
    ) i_timer (
        .clk     (clk),
        .rst     (rst),
        .hsync_i (hsync),
        .en_i    (ttx_en),
        .dly_i   (req_dly),
        .done_i  (seq_done),
        .req_o   (ttx_req),
        .start_o (seq_start)
    );

    ttx_bit_sched #(
        .NBITS    (NBITS),
        .GRP      (GRP),
        .STRIDE   (STRIDE),
        .LONG_CLK (LONG_CLK),
        .IW       (IDX_W)
    ) i_sched (
        .clk     (clk),
        .rst     (rst),
        .start_i (seq_start),
        .data_i  (ttx_din),
        .vld_o   (bit_vld),
        .dat_o   (bit_data),
        .idx_o   (bit_idx),
        .done_o  (seq_done)
    );

    assign line_done = seq_done;

    // R7: request window has closed by the end-of-line cycle
    a_r7_req_closed: assert property (@(posedge clk) disable iff (rst)
        line_done |-> !ttx_req);

    // R1: reset leaves every output quiet in the following cycle
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!ttx_req && !bit_vld && !line_done));

endmodule

// File: tb/test_ttx_bit_sequencer.sv
module test_ttx_bit_sequencer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync = 1'b0;
    logic       ttx_en = 1'b0;
    logic [3:0] req_dly = 4'd0;
    logic       ttx_din = 1'b0;
    logic       ttx_req, bit_vld, bit_data, line_done;
    logic [8:0] bit_idx;

    int total = 0;
    int bad = 0;
    int st [360];

    always #2 clk = ~clk;

    ttx_bit_sequencer i_ttx_bit_sequencer (
        .clk       (clk),
        .rst       (rst),
        .hsync     (hsync),
        .ttx_en    (ttx_en),
        .req_dly   (req_dly),
        .ttx_req   (ttx_req),
        .ttx_din   (ttx_din),
        .bit_vld   (bit_vld),
        .bit_data  (bit_data),
        .bit_idx   (bit_idx),
        .line_done (line_done)
    );

    function automatic int pat(input int j);
        if (j < 0) return 0;
        return ((j * 29 + (j >> 3)) >> 1) & 1;
    endfunction

    task automatic chk(input string lbl, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", lbl, act, exp);
        end
    endtask

    // One line: the edge clock follows the first negedge; k counts cycles after it.
    task automatic run_line(input int d, input bit en, input int hk,
                            input int dchg, input int last, input string tag);
        int  nb;
        bit  ev;
        nb = 0;
        @(negedge clk);
        hsync   = 1'b1;
        ttx_en  = en;
        req_dly = 4'(d);
        ttx_din = 1'b0;
        for (int k = 0; k <= last; k++) begin
            @(negedge clk);
            hsync = (k == hk);
            if (k == dchg) req_dly = 4'(15 - d);
            ttx_din = 1'(pat(k - 275));
            chk({tag, en ? " R3 req window" : " R2 no req when disabled"},
                int'(ttx_req), int'(en && k >= 275 - d && k < 275 - d + 1402));
            ev = en && nb < 360 && (k - 1) == 275 + st[nb];
            chk({tag, " R5 strobe timing"}, int'(bit_vld), int'(ev));
            if (ev && bit_vld) begin
                chk({tag, " R4 data"}, int'(bit_data), pat(st[nb]));
                chk({tag, " R6 idx"}, int'(bit_idx), nb);
            end
            if (ev) nb++;
            chk({tag, " R7 done"}, int'(line_done), int'(en && k == 1677));
        end
        if (en && last >= 1677) chk({tag, " R4 bit count"}, nb, 360);
    endtask

    task automatic t_reset;
        chk("R1 reset req", int'(ttx_req), 0);
        chk("R1 reset vld", int'(bit_vld), 0);
        chk("R1 reset done", int'(line_done), 0);
    endtask

    task automatic t_basic;
        run_line(0, 1'b1, -5, -5, 1700, "d0");
        run_line(15, 1'b1, -5, -5, 1700, "d15");
    endtask

    task automatic t_mid_hsync;
        run_line(7, 1'b1, 500, -5, 1700, "R8 mid-line edge");
    endtask

    task automatic t_dly_change;
        run_line(5, 1'b1, -5, 100, 1700, "R9 delay change");
    endtask

    task automatic t_disabled;
        run_line(4, 1'b0, -5, -5, 1700, "R2 disabled");
    endtask

    task automatic t_collision;
        // edge lands on the line_done cycle and must be ignored
        run_line(2, 1'b1, 1677, -5, 1678, "R8 edge at done");
        // an edge soon after is accepted and runs a full line
        run_line(9, 1'b1, -5, -5, 1700, "R8 next line");
    endtask

    task automatic t_reset_mid;
        run_line(3, 1'b1, -5, -5, 400, "R1 pre-reset");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t_reset;
        for (int k = 0; k < 1800; k++) begin
            @(negedge clk);
            chk("R1 idle req", int'(ttx_req), 0);
            chk("R1 idle vld", int'(bit_vld), 0);
            chk("R1 idle done", int'(line_done), 0);
        end
    endtask

    initial begin
        int s;
        s = 0;
        for (int b = 0; b < 360; b++) begin
            st[b] = s;
            s += ((b % 37 != 0) && ((b % 37) % 9 == 0)) ? 3 : 4;
        end
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        t_basic;
        t_mid_hsync;
        t_dly_change;
        t_disabled;
        t_collision;
        t_reset_mid;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule